// File: doc/BRIEF.md
# Port Statistics Operation Engine

This block owns a bank of per-port event counters and the small command machine that software uses to maintain them. Each port has a fixed number of counters. Each counter has its own increment strobe and counts one per strobe, saturating instead of wrapping. Software drives everything through three 16-bit registers on a simple write/read interface: an operation register and two result halves.

A command is issued by writing the operation register with its top bit set. The command can clear every counter, clear the counters of one port, freeze one port's counters into a capture buffer, or fetch one counter into the result registers. The fetch reads either the capture buffer or the live bank. The top bit reads back as busy until the command has finished, and writes that arrive meanwhile are discarded. To collect a consistent view of one port, software issues a capture and then fetches captured counter indices from 0 upward.

Top module: `pstat_engine`

## Requirements
- R1: After reset the operation register, both result halves and every counter read 0.
- R2: The operation register at address 0 holds busy in bit 15, the opcode in bits [14:12], the histogram mode in [11:10], the port field in [9:5] (port number plus one, 0 meaning no port) and the counter index in [4:0]. An idle write with bit 15 set starts a command, and bit 15 reads 1 from the cycle after that write until the command ends.
- R3: Any write to the operation register while busy is 1 changes no register field, no counter and no result.
- R4: An idle write stores bits [11:10] as the histogram mode, which reads back unchanged and has no effect on counting.
- R5: A counter grows by exactly one for each cycle its increment strobe is high, and it holds at all ones once it gets there.
- R6: Opcode 1 clears every counter, one per cycle. Busy reads 1 for 1 + ports*counters cycles, and increments arriving during the command are lost.
- R7: Opcode 2 clears only the counters of the selected port, with busy lasting 1 + counters cycles. Increments to that port during the command are lost, while increments to other ports still count.
- R8: Opcode 5 copies all counters of the selected port into the capture buffer in one step, with busy lasting one cycle. Later increments do not change the buffer.
- R9: Opcode 4 loads the result with capture-buffer entry [index], with busy lasting one cycle.
- R10: Opcode 6 loads the result with the live value of the selected port's counter [index], with busy lasting one cycle.
- R11: Address 1 reads result bits [31:16] and address 2 reads bits [15:0]. Values narrower than 32 bits are zero-extended.
- R12: Opcodes 0, 3 and 7, a port field of 0 or above the port count where a port is needed, and an index at or above the counter count where an index is needed each clear busy after one cycle and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 operation, 1 result high, 2 result low |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| cnt_inc | input | NUM_PORTS*NUM_CTRS | Increment strobes, bit port*NUM_CTRS+index |

## Verification
On every cycle, the checker verifies the following. A counter moves only by holding, by stepping up one or by dropping to zero, and it holds once saturated outside a command. The result halves stay still whenever the engine is idle. A busy write leaves the register fields alone, and a clear-all command always ends with an all-zero bank. The bench scenarios are the only place to show the rest: exact busy lengths per opcode, which port a clear touches, and the loss of increments during a clear. They also show that captured values stay frozen while live ones move on, and that bad commands leave the result untouched, all compared against counts worked out in the bench.

// File: rtl/pstat_pkg.sv
package pstat_pkg;
  localparam int RES_W    = 32;
  localparam int BUSY_POS = 15;
  localparam int OPC_LSB  = 12;
  localparam int HIST_LSB = 10;
  localparam int PFLD_LSB = 5;
  localparam int PFLD_W   = 5;
  localparam int IDX_W    = 5;

  localparam logic [2:0] OPC_FLUSH_ALL  = 3'd1;
  localparam logic [2:0] OPC_FLUSH_PORT = 3'd2;
  localparam logic [2:0] OPC_READ_SNAP  = 3'd4;
  localparam logic [2:0] OPC_CAPTURE    = 3'd5;
  localparam logic [2:0] OPC_READ_LIVE  = 3'd6;

  localparam logic [1:0] ADDR_OPREG  = 2'd0;
  localparam logic [1:0] ADDR_RES_HI = 2'd1;
  localparam logic [1:0] ADDR_RES_LO = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EXEC  = 2'd1,
    ST_FLUSH = 2'd2
  } eng_state_e;
endpackage

// File: rtl/pstat_ctr_bank.sv
module pstat_ctr_bank #(
  parameter int NP = 4,
  parameter int NC = 8,
  parameter int CW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NP*NC-1:0]           inc_i,
  input  logic [NP-1:0]              drop_i,
  input  logic                       clr_en_i,
  input  logic [$clog2(NP*NC)-1:0]   clr_idx_i,
  output logic [NP*NC*CW-1:0]        cnt_o
);
  localparam int NS     = NP * NC;
  localparam int SLOT_W = $clog2(NS);

  for (genvar s = 0; s < NS; s++) begin : g_slot
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          cnt_ce;
    logic          clr_hit;
    logic          inc_ok;

    always_comb begin
      clr_hit = clr_en_i && (clr_idx_i == SLOT_W'(s));
      inc_ok  = inc_i[s] && !drop_i[s / NC] && (cnt_q != {CW{1'b1}});
      cnt_ce  = clr_hit || inc_ok;
      cnt_d   = clr_hit ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_ce) begin
        cnt_q <= cnt_d;
      end
    end

    assign cnt_o[s*CW +: CW] = cnt_q;
  end
endmodule

// File: rtl/pstat_snapshot.sv
module pstat_snapshot #(
  parameter int NP = 4,
  parameter int NC = 8,
  parameter int CW = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cap_en_i,
  input  logic [((NP > 1) ? $clog2(NP) : 1)-1:0] cap_port_i,
  input  logic [NP*NC*CW-1:0]                live_i,
  output logic [NC*CW-1:0]                   snap_o
);
  for (genvar c = 0; c < NC; c++) begin : g_entry
    logic [CW-1:0] snap_q;
    logic [CW-1:0] snap_d;

    always_comb begin
      snap_d = live_i[(int'(cap_port_i) * NC + c) * CW +: CW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        snap_q <= '0;
      end else if (cap_en_i) begin
        snap_q <= snap_d;
      end
    end

    assign snap_o[c*CW +: CW] = snap_q;
  end
endmodule

// File: rtl/pstat_cmd_ctrl.sv
module pstat_cmd_ctrl
  import pstat_pkg::*;
#(
  parameter int NP = 4,
  parameter int NC = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en_i,
  input  logic [1:0]                           addr_i,
  input  logic [15:0]                          wdata_i,
  output logic [15:0]                          op_reg_o,
  output logic                                 busy_o,
  output logic                                 clr_en_o,
  output logic [$clog2(NP*NC)-1:0]             clr_idx_o,
  output logic [NP-1:0]                        drop_o,
  output logic                                 cap_en_o,
  output logic                                 rd_snap_en_o,
  output logic                                 rd_live_en_o,
  output logic [((NP > 1) ? $clog2(NP) : 1)-1:0] sel_port_o,
  output logic [((NC > 1) ? $clog2(NC) : 1)-1:0] sel_idx_o
);
  localparam int NS     = NP * NC;
  localparam int SLOT_W = $clog2(NS);
  localparam int PSEL_W = (NP > 1) ? $clog2(NP) : 1;
  localparam int CSEL_W = (NC > 1) ? $clog2(NC) : 1;

  eng_state_e        state_q, state_d;
  logic [2:0]        opc_q, opc_d;
  logic [1:0]        hist_q, hist_d;
  logic [PFLD_W-1:0] pfld_q, pfld_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [SLOT_W-1:0] ptr_q, ptr_d;
  logic [SLOT_W-1:0] last_q, last_d;

  logic              accept;
  logic              port_ok;
  logic              idx_ok;
  logic [PFLD_W-1:0] port_num;

  always_comb begin
    accept   = wr_en_i && (addr_i == ADDR_OPREG) && (state_q == ST_IDLE);
    port_ok  = (pfld_q != '0) && (int'(pfld_q) <= NP);
    idx_ok   = int'(idx_q) < NC;
    port_num = pfld_q - PFLD_W'(1);
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    opc_d   = opc_q;
    hist_d  = hist_q;
    pfld_d  = pfld_q;
    idx_d   = idx_q;
    ptr_d   = ptr_q;
    last_d  = last_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          opc_d  = wdata_i[OPC_LSB +: 3];
          hist_d = wdata_i[HIST_LSB +: 2];
          pfld_d = wdata_i[PFLD_LSB +: PFLD_W];
          idx_d  = wdata_i[IDX_W-1:0];
          if (wdata_i[BUSY_POS]) state_d = ST_EXEC;
        end
      end
      ST_EXEC: begin
        state_d = ST_IDLE;
        if (opc_q == OPC_FLUSH_ALL) begin
          ptr_d   = '0;
          last_d  = SLOT_W'(NS - 1);
          state_d = ST_FLUSH;
        end else if ((opc_q == OPC_FLUSH_PORT) && port_ok) begin
          ptr_d   = SLOT_W'(int'(sel_port_o) * NC);
          last_d  = SLOT_W'(int'(sel_port_o) * NC + NC - 1);
          state_d = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        if (ptr_q == last_q) begin
          state_d = ST_IDLE;
        end else begin
          ptr_d = ptr_q + SLOT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      opc_q   <= '0;
      hist_q  <= '0;
      pfld_q  <= '0;
      idx_q   <= '0;
      ptr_q   <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        opc_q  <= opc_d;
        hist_q <= hist_d;
        pfld_q <= pfld_d;
        idx_q  <= idx_d;
      end
      if (state_q != ST_IDLE) begin
        ptr_q  <= ptr_d;
        last_q <= last_d;
      end
    end
  end

  // outputs
  always_comb begin
    busy_o       = (state_q != ST_IDLE);
    op_reg_o     = {busy_o, opc_q, hist_q, pfld_q, idx_q};
    sel_port_o   = port_num[PSEL_W-1:0];
    sel_idx_o    = idx_q[CSEL_W-1:0];
    clr_en_o     = (state_q == ST_FLUSH);
    clr_idx_o    = ptr_q;
    cap_en_o     = (state_q == ST_EXEC) && (opc_q == OPC_CAPTURE) && port_ok;
    rd_snap_en_o = (state_q == ST_EXEC) && (opc_q == OPC_READ_SNAP) && idx_ok;
    rd_live_en_o = (state_q == ST_EXEC) && (opc_q == OPC_READ_LIVE) && port_ok && idx_ok;
    for (int p = 0; p < NP; p++) begin
      drop_o[p] = (state_q == ST_FLUSH) &&
                  ((opc_q == OPC_FLUSH_ALL) || (int'(sel_port_o) == p));
    end
  end
endmodule

// File: rtl/pstat_engine.sv
module pstat_engine
  import pstat_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_CTRS  = 8,
  parameter int CTR_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr_en,
  input  logic [1:0]                    reg_addr,
  input  logic [15:0]                   reg_wdata,
  output logic [15:0]                   reg_rdata,
  input  logic [NUM_PORTS*NUM_CTRS-1:0] cnt_inc
);
  localparam int NS     = NUM_PORTS * NUM_CTRS;
  localparam int SLOT_W = $clog2(NS);
  localparam int PSEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int CSEL_W = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1;

  logic [15:0]          op_reg;
  logic                 busy;
  logic                 clr_en;
  logic [SLOT_W-1:0]    clr_idx;
  logic [NUM_PORTS-1:0] drop;
  logic                 cap_en;
  logic                 rd_snap_en;
  logic                 rd_live_en;
  logic [PSEL_W-1:0]    sel_port;
  logic [CSEL_W-1:0]    sel_idx;
  logic [NS*CTR_W-1:0]  live_flat;
  logic [NUM_CTRS*CTR_W-1:0] snap_flat;
  logic [RES_W-1:0]     res_q, res_d;
  logic                 res_ce;

  pstat_cmd_ctrl #(.NP(NUM_PORTS), .NC(NUM_CTRS)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (reg_wr_en),
    .addr_i       (reg_addr),
    .wdata_i      (reg_wdata),
    .op_reg_o     (op_reg),
    .busy_o       (busy),
    .clr_en_o     (clr_en),
    .clr_idx_o    (clr_idx),
    .drop_o       (drop),
    .cap_en_o     (cap_en),
    .rd_snap_en_o (rd_snap_en),
    .rd_live_en_o (rd_live_en),
    .sel_port_o   (sel_port),
    .sel_idx_o    (sel_idx)
  );

  pstat_ctr_bank #(.NP(NUM_PORTS), .NC(NUM_CTRS), .CW(CTR_W)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_i     (cnt_inc),
    .drop_i    (drop),
    .clr_en_i  (clr_en),
    .clr_idx_i (clr_idx),
    .cnt_o     (live_flat)
  );

  pstat_snapshot #(.NP(NUM_PORTS), .NC(NUM_CTRS), .CW(CTR_W)) snap_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en_i   (cap_en),
    .cap_port_i (sel_port),
    .live_i     (live_flat),
    .snap_o     (snap_flat)
  );

  // result next-state
  always_comb begin
    res_d  = '0;
    res_ce = rd_snap_en || rd_live_en;
    if (rd_snap_en) begin
      res_d[CTR_W-1:0] = snap_flat[int'(sel_idx) * CTR_W +: CTR_W];
    end else begin
      res_d[CTR_W-1:0] =
        live_flat[(int'(sel_port) * NUM_CTRS + int'(sel_idx)) * CTR_W +: CTR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_ce) begin
      res_q <= res_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_OPREG:  reg_rdata = op_reg;
      ADDR_RES_HI: reg_rdata = res_q[31:16];
      ADDR_RES_LO: reg_rdata = res_q[15:0];
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pstat_engine_chk.sv
module pstat_engine_chk
  import pstat_pkg::*;
#(
  parameter int NP = 4,
  parameter int NC = 8,
  parameter int CW = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr,
  input logic [1:0]          addr,
  input logic [15:0]         wdata,
  input logic [15:0]         oreg,
  input logic                busy,
  input logic [RES_W-1:0]    res,
  input logic [NP*NC*CW-1:0] live
);
  // R2: an idle start write raises busy
  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr && addr == ADDR_OPREG && wdata[BUSY_POS]) |=> busy);

  // R3: busy writes leave all fields alone
  p_busy_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr && addr == ADDR_OPREG) |=> (oreg[14:0] == $past(oreg[14:0])));

  // R9, R10: result moves only as a command ends
  p_result_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(res));

  // R6: clear-all ends with an empty bank
  p_flush_all_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && oreg[OPC_LSB +: 3] == OPC_FLUSH_ALL) |-> (live == '0));

  for (genvar s = 0; s < NP*NC; s++) begin : g_ctr
    // R5: saturated counter holds outside commands
    p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && live[s*CW +: CW] == {CW{1'b1}}) |=> (live[s*CW +: CW] == {CW{1'b1}}));
    // R5: a counter holds, steps by one or is cleared
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((live[s*CW +: CW] == $past(live[s*CW +: CW])) ||
                (live[s*CW +: CW] == ($past(live[s*CW +: CW]) + CW'(1))) ||
                (live[s*CW +: CW] == '0)));
  end
endmodule

bind pstat_engine pstat_engine_chk #(
  .NP(NUM_PORTS), .NC(NUM_CTRS), .CW(CTR_W)
) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .wr    (reg_wr_en),
  .addr  (reg_addr),
  .wdata (reg_wdata),
  .oreg  (op_reg),
  .busy  (busy),
  .res   (res_q),
  .live  (live_flat)
);

// File: tb/pstat_engine_tb.sv
module pstat_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NC = 8;
  localparam int CW = 17;
  localparam int NS = NP * NC;
  localparam int MAXV = (1 << CW) - 1;
  localparam logic [1:0] HIST = 2'b10;

  logic          clk;
  logic          rst_n;
  logic          reg_wr_en;
  logic [1:0]    reg_addr;
  logic [15:0]   reg_wdata;
  logic [15:0]   reg_rdata;
  logic [NS-1:0] cnt_inc;

  int n_checks;
  int n_fails;
  int expc [NS];

  pstat_engine #(.NUM_PORTS(NP), .NUM_CTRS(NC), .CTR_W(CW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cnt_inc   (cnt_inc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] want);
    n_checks++;
    if (got !== want) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, want);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr_en = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  function automatic logic [15:0] mk(input logic [2:0] op, input int pf, input int ix);
    return {1'b1, op, HIST, 5'(pf), 5'(ix)};
  endfunction

  task automatic wait_idle(output int cyc);
    logic [15:0] v;
    cyc = 0;
    rd(2'd0, v);
    while (v[15]) begin
      cyc++;
      @(negedge clk);
      rd(2'd0, v);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input int pf, input int ix, output int cyc);
    wr(2'd0, mk(op, pf, ix));
    wait_idle(cyc);
  endtask

  task automatic getres(output logic [31:0] v);
    logic [15:0] h, l;
    rd(2'd1, h);
    rd(2'd2, l);
    v = {h, l};
  endtask

  task automatic pulse(input logic [NS-1:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      cnt_inc = m;
      for (int s = 0; s < NS; s++) if (m[s] && expc[s] < MAXV) expc[s]++;
      @(negedge clk);
    end
    cnt_inc = '0;
  endtask

  task automatic check_live_all(input string tag);
    int cyc;
    logic [31:0] v;
    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < NC; c++) begin
        cmd(3'd6, p + 1, c, cyc);
        getres(v);
        chk(tag, v, 32'(expc[p*NC+c]));
      end
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] v16;
    logic [31:0] v, held;
    logic [31:0] snapv [NC];
    n_checks = 0;
    n_fails = 0;
    rst_n = 1'b0;
    reg_wr_en = 1'b0;
    reg_addr = 2'd0;
    reg_wdata = '0;
    cnt_inc = '0;
    for (int s = 0; s < NS; s++) expc[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v16); chk("R1 opreg", 32'(v16), 0);
    rd(2'd1, v16); chk("R1 res hi", 32'(v16), 0);
    rd(2'd2, v16); chk("R1 res lo", 32'(v16), 0);
    check_live_all("R1 counters zero");

    // R4 histogram mode stored by a non-start write
    wr(2'd0, 16'h0800);
    rd(2'd0, v16); chk("R4 hist stored", 32'(v16), 32'h0800);

    // R5 counting: slot s gets s+1 pulses; R4 mode has no effect
    for (int k = 0; k < NS; k++) begin
      logic [NS-1:0] m;
      for (int s = 0; s < NS; s++) m[s] = (s + 1 > k);
      pulse(m, 1);
    end
    cmd(3'd6, 2, 3, cyc);
    chk("R10 live busy cycles", 32'(cyc), 1);
    rd(2'd0, v16); chk("R2 opreg layout", 32'(v16), {16'h0, mk(3'd6, 2, 3) & 16'h7FFF});
    check_live_all("R5 R10 live counts");

    // R8 capture port 2, R9 captured reads stay frozen
    cmd(3'd5, 3, 0, cyc);
    chk("R8 capture busy cycles", 32'(cyc), 1);
    for (int c = 0; c < NC; c++) snapv[c] = 32'(expc[2*NC+c]);
    pulse({NS{1'b1}}, 3);
    for (int c = 0; c < NC; c++) begin
      cmd(3'd4, 0, c, cyc);
      chk("R9 snap busy cycles", 32'(cyc), 1);
      getres(v);
      chk("R9 captured value", v, snapv[c]);
    end
    check_live_all("R8 live moves on");

    // R7 flush port 1 (field 2)
    cmd(3'd2, 2, 0, cyc);
    chk("R7 flush port busy cycles", 32'(cyc), 1 + NC);
    for (int c = 0; c < NC; c++) expc[1*NC+c] = 0;
    check_live_all("R7 only port 1 cleared");

    // R7 increments to the flushed port lost, others counted
    wr(2'd0, mk(3'd2, 4, 0));
    begin
      logic [NS-1:0] m;
      m = '0;
      for (int c = 0; c < NC; c++) begin
        m[3*NC+c] = 1'b1;
        m[0*NC+c] = 1'b1;
      end
      pulse(m, 5);
    end
    wait_idle(cyc);
    for (int c = 0; c < NC; c++) expc[3*NC+c] = 0;
    check_live_all("R7 drop during flush");

    // R12 invalid commands leave result and counters alone
    cmd(3'd6, 1, 2, cyc);
    getres(held);
    chk("R10 reference read", held, 32'(expc[2]));
    cmd(3'd3, 1, 1, cyc);
    chk("R12 opcode 3 busy cycles", 32'(cyc), 1);
    getres(v); chk("R12 opcode 3 result", v, held);
    cmd(3'd7, 1, 1, cyc);
    getres(v); chk("R12 opcode 7 result", v, held);
    cmd(3'd6, 0, 1, cyc);
    getres(v); chk("R12 port field zero", v, held);
    cmd(3'd6, NP + 1, 1, cyc);
    getres(v); chk("R12 port field high", v, held);
    cmd(3'd6, 1, NC, cyc);
    getres(v); chk("R12 index high", v, held);
    cmd(3'd4, 0, NC + 1, cyc);
    getres(v); chk("R12 snap index high", v, held);
    cmd(3'd2, 0, 0, cyc);
    chk("R12 flush no port busy", 32'(cyc), 1);
    cmd(3'd5, 0, 0, cyc);
    cmd(3'd4, 0, 0, cyc);
    getres(v); chk("R12 bad capture keeps buffer", v, snapv[0]);
    getres(held);
    check_live_all("R12 counters intact");

    // R6 flush all, with R3 busy write ignored and increments lost
    cmd(3'd6, 1, 0, cyc);
    getres(held);
    wr(2'd0, mk(3'd1, 0, 0));
    wr(2'd0, mk(3'd6, 2, 1));
    pulse({NS{1'b1}}, 4);
    wait_idle(cyc);
    chk("R6 flush all busy cycles", 32'(cyc + 5), 1 + NS);
    rd(2'd0, v16); chk("R3 opreg after busy write", 32'(v16), 32'h1800);
    getres(v); chk("R3 result unchanged", v, held);
    for (int s = 0; s < NS; s++) expc[s] = 0;
    check_live_all("R6 all cleared");

    // R5 saturation, R11 split across halves
    pulse({NS{1'b1}}, MAXV + 4);
    cmd(3'd6, 3, 5, cyc);
    rd(2'd1, v16); chk("R11 high half", 32'(v16), 32'h1);
    rd(2'd2, v16); chk("R11 low half", 32'(v16), 32'hFFFF);
    check_live_all("R5 saturated");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule